// File: doc/BRIEF.md
# Character LCD Bus Transaction Engine

This block sits on the host side of a parallel character-display bus. It carries out one register access at a time: an instruction write, a data write, a status read (busy flag plus address counter) or a data read. It drives the register-select line, the read/write line and the enable strobe, and it drives or samples the eight data lines. A client raises a request with a byte, a register-select value, a direction flag and a width select. The engine returns a one-cycle acknowledge, together with the byte it read.

All bus timing comes from parameters. The control setup before the enable strobe, the strobe high time, the full strobe period, the read-data valid delay and the control hold after the strobe falls are each given in nanoseconds. Each is converted to clock cycles against the clock frequency and rounded up.

In narrow mode only the upper four data lines carry information. Every byte then takes two strobes, high nibble first. A busy-poll request repeats status reads until the busy bit (bit 7 of the status byte) reads 0. It then acknowledges with that final status byte, whose low seven bits are the address counter.

Top module: `lcd_bus_engine`

## Requirements
- R1: After reset, and whenever no request is in progress, the enable strobe, register select, read/write line, data output enable and acknowledge are all 0, and the data output is 0.
- R2: A request is taken only while idle. For the whole transaction, register select follows `req_rs` and read/write follows `req_rw` (1 = read). A poll request (`req_poll`=1) forces register select to 0 and read/write to 1.
- R3: Register select and read/write are stable for at least ceil(140 ns × f) cycles before each rising edge of the strobe. That is 28 cycles at 200 MHz.
- R4: Each strobe stays high for max(ceil(450 ns × f), ceil(320 ns × f)+1) cycles, which is 90 cycles at 200 MHz. The time from one rising edge to the next is at least ceil(1000 ns × f) cycles, which is 200 cycles at 200 MHz.
- R5: The data output enable is 1 only during write transactions, and only while read/write is 0. In wide mode (`req_nib`=0), the data output carries the whole byte. When the enable is 0, the data output is 0.
- R6: In narrow mode (`req_nib`=1), a transfer uses two strobes. The first carries byte bits 7..4 on data lines 7..4; the second carries bits 3..0 on those lines. Data lines 3..0 are driven 0.
- R7: A read samples the data lines on the clock edge that ends the strobe-high interval, which is no earlier than 320 ns after the rising edge. Values present earlier in the strobe have no effect. `ack_data` returns the byte read; after a write it returns 0.
- R8: In a narrow read, data lines 7..4 of the first strobe become bits 7..4 of the result, and those of the second strobe become bits 3..0. Data lines 3..0 are ignored.
- R9: A poll request repeats complete status reads (one or two strobes each) while bit 7 of the assembled byte is 1. It acknowledges with the first byte whose bit 7 is 0.
- R10: The acknowledge is a single-cycle pulse in the cycle after the last strobe-low interval. In that cycle read/write and the output enable are already back to 0.
- R11: Register select and read/write stay unchanged for the whole strobe-low interval after each falling edge (82 cycles at 200 MHz).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Request, held until acknowledge |
| req_rs | input | 1 | Register select for the access (0 instruction/status, 1 data) |
| req_rw | input | 1 | Direction, 1 = read |
| req_poll | input | 1 | Repeat status reads until the busy bit clears |
| req_nib | input | 1 | 1 = 4-bit transfers on the upper data lines |
| req_byte | input | 8 | Byte to write |
| ack | output | 1 | One-cycle completion pulse |
| ack_data | output | 8 | Byte read (0 after a write) |
| lcd_rs | output | 1 | Bus register select |
| lcd_rw | output | 1 | Bus read/write |
| lcd_e | output | 1 | Bus enable strobe |
| lcd_db_out | output | 8 | Data lines driven by the engine |
| lcd_db_oe | output | 1 | Drive enable for the data lines |
| lcd_db_in | input | 8 | Data lines as seen from the bus |

## Verification
The properties assume that a client keeps `req` and its fields steady from the moment it raises the request until the acknowledge, and releases `req` in the acknowledge cycle. They also assume that the display side presents read data by the end of the strobe-high interval. The stimulus meets these conditions through a single request task that holds every field until completion and drops `req` as soon as the acknowledge is seen. The modelled display drives a junk byte with bit 7 set until 320 ns after each rising edge, and only then the planned value. A design that samples too early therefore returns wrong data and can stall in the busy poll.

// File: rtl/lcd_bus_pkg.sv
// Shared definitions for the character-display bus engine.
// Assumes: timing values are given in ns and the clock in whole MHz.
package lcd_bus_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = BYTE_W / 2;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_HIGH  = 2'd2,
        PH_LOW   = 2'd3
    } phase_t;

    // Round a nanosecond interval up to whole clock cycles.
    function automatic int ns_to_cyc(input int ns, input int mhz);
        return (ns * mhz + 999) / 1000;
    endfunction

    // Larger of two integers.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lcd_phase_timer.sv
// Down-counter that times one strobe phase.
// A load of N makes `expired` rise in the N-th cycle after the load edge.
// Assumes: load values are at least 1.
module lcd_phase_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt;

    // Count down the remaining cycles of the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val - CW'(1);
        else if (cnt != '0)  cnt <= cnt - CW'(1);
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/lcd_lane_mux.sv
// Data-lane steering: picks the byte or nibble that is driven, and
// assembles read bytes from one or two captures.
// Assumes: the capture enable is a single cycle at the end of a strobe.
module lcd_lane_mux
    import lcd_bus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nib_mode,
    input  logic              second,
    input  logic              drive,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic              cap_en,
    input  logic              cap_clr,
    input  logic [BYTE_W-1:0] db_in,
    output logic [BYTE_W-1:0] db_out,
    output logic [BYTE_W-1:0] cap
);

    // Select what appears on the outgoing lines.
    always_comb begin
        if (!drive)        db_out = '0;
        else if (!nib_mode) db_out = wbyte;
        else if (!second)  db_out = {wbyte[BYTE_W-1:NIB_W], {NIB_W{1'b0}}};
        else               db_out = {wbyte[NIB_W-1:0], {NIB_W{1'b0}}};
    end

    // Build the read byte from the upper lines or the full bus.
    always_ff @(posedge clk) begin
        if (!rst_n || cap_clr) begin
            cap <= '0;
        end else if (cap_en) begin
            if (!nib_mode)    cap <= db_in;
            else if (!second) cap[BYTE_W-1:NIB_W] <= db_in[BYTE_W-1:NIB_W];
            else              cap[NIB_W-1:0] <= db_in[BYTE_W-1:NIB_W];
        end
    end

endmodule

// File: rtl/lcd_bus_engine.sv
// Host-side engine for one register access on a parallel character-display
// bus: setup, strobe high, strobe low per transfer, two transfers per byte
// in nibble mode, optional repeat of status reads until the busy bit clears.
// Assumes: request fields stay constant while req is high; req drops in the
// acknowledge cycle.
module lcd_bus_engine
    import lcd_bus_pkg::*;
#(
    parameter int CLK_MHZ   = 200,
    parameter int SETUP_NS  = 140,
    parameter int EHIGH_NS  = 450,
    parameter int ECYCLE_NS = 1000,
    parameter int DVALID_NS = 320,
    parameter int HOLD_NS   = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_rs,
    input  logic              req_rw,
    input  logic              req_poll,
    input  logic              req_nib,
    input  logic [BYTE_W-1:0] req_byte,
    output logic              ack,
    output logic [BYTE_W-1:0] ack_data,
    output logic              lcd_rs,
    output logic              lcd_rw,
    output logic              lcd_e,
    output logic [BYTE_W-1:0] lcd_db_out,
    output logic              lcd_db_oe,
    input  logic [BYTE_W-1:0] lcd_db_in
);

    localparam int NS  = imax(ns_to_cyc(SETUP_NS, CLK_MHZ), 1);
    localparam int NH  = imax(imax(ns_to_cyc(EHIGH_NS, CLK_MHZ),
                                   ns_to_cyc(DVALID_NS, CLK_MHZ) + 1), 1);
    localparam int NCY = ns_to_cyc(ECYCLE_NS, CLK_MHZ);
    localparam int NL  = imax(imax(NCY - NS - NH, ns_to_cyc(HOLD_NS, CLK_MHZ)), 1);
    localparam int CW  = $clog2(imax(imax(NS, NH), NL) + 1);

    phase_t            ph, ph_n;
    logic              nib_mode, poll_mode, second;
    logic [BYTE_W-1:0] wbyte, cap;
    logic              tmr_load, tmr_exp;
    logic [CW-1:0]     tmr_val;
    logic              more_pulse, repoll, finish, accept;

    assign accept     = (ph == PH_IDLE) && req;
    assign more_pulse = nib_mode && !second;
    assign repoll     = poll_mode && cap[BYTE_W-1];
    assign finish     = (ph == PH_LOW) && tmr_exp && !more_pulse && !repoll;

    // Next phase and the timer value for that phase.
    always_comb begin
        ph_n     = ph;
        tmr_load = 1'b0;
        tmr_val  = CW'(NS);
        unique case (ph)
            PH_IDLE: if (req) begin
                ph_n = PH_SETUP; tmr_load = 1'b1; tmr_val = CW'(NS);
            end
            PH_SETUP: if (tmr_exp) begin
                ph_n = PH_HIGH; tmr_load = 1'b1; tmr_val = CW'(NH);
            end
            PH_HIGH: if (tmr_exp) begin
                ph_n = PH_LOW; tmr_load = 1'b1; tmr_val = CW'(NL);
            end
            PH_LOW: if (tmr_exp) begin
                if (more_pulse || repoll) begin
                    ph_n = PH_SETUP; tmr_load = 1'b1; tmr_val = CW'(NS);
                end else begin
                    ph_n = PH_IDLE;
                end
            end
            default: ph_n = PH_IDLE;
        endcase
    end

    // Phase register, bus control lines, request latch and acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph        <= PH_IDLE;
            lcd_rs    <= 1'b0;
            lcd_rw    <= 1'b0;
            lcd_db_oe <= 1'b0;
            ack       <= 1'b0;
            nib_mode  <= 1'b0;
            poll_mode <= 1'b0;
            second    <= 1'b0;
            wbyte     <= '0;
        end else begin
            ph  <= ph_n;
            ack <= 1'b0;
            if (accept) begin
                lcd_rs    <= req_poll ? 1'b0 : req_rs;
                lcd_rw    <= req_poll | req_rw;
                lcd_db_oe <= !(req_poll | req_rw);
                wbyte     <= req_byte;
                nib_mode  <= req_nib;
                poll_mode <= req_poll;
                second    <= 1'b0;
            end
            if (ph == PH_LOW && tmr_exp) begin
                if (more_pulse) begin
                    second <= 1'b1;
                end else if (repoll) begin
                    second <= 1'b0;
                end else begin
                    ack       <= 1'b1;
                    lcd_rs    <= 1'b0;
                    lcd_rw    <= 1'b0;
                    lcd_db_oe <= 1'b0;
                end
            end
        end
    end

    assign lcd_e    = (ph == PH_HIGH);
    assign ack_data = cap;

    lcd_phase_timer #(.CW(CW)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    lcd_lane_mux lanes_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .nib_mode (nib_mode),
        .second   (second),
        .drive    (lcd_db_oe),
        .wbyte    (wbyte),
        .cap_en   ((ph == PH_HIGH) && tmr_exp && lcd_rw),
        .cap_clr  (accept),
        .db_in    (lcd_db_in),
        .db_out   (lcd_db_out),
        .cap      (cap)
    );

    logic unused_finish;
    assign unused_finish = finish;

endmodule

// File: rtl/lcd_bus_engine_chk.sv
// Protocol checker for the bus engine: strobe widths, setup, hold,
// drive direction and acknowledge shape. Counters measure the long windows.
module lcd_bus_engine_chk #(
    parameter int NS  = 28,
    parameter int NH  = 90,
    parameter int NCY = 200
) (
    input logic clk,
    input logic rst_n,
    input logic lcd_e,
    input logic lcd_rs,
    input logic lcd_rw,
    input logic lcd_db_oe,
    input logic ack
);

    logic        e_q;
    logic [1:0]  ctl_q;
    logic [31:0] ctl_age, hi_len, since_rise;

    // Track control age, strobe high length and strobe period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q        <= 1'b0;
            ctl_q      <= 2'b00;
            ctl_age    <= '1;
            hi_len     <= '0;
            since_rise <= '1;
        end else begin
            e_q        <= lcd_e;
            ctl_q      <= {lcd_rs, lcd_rw};
            ctl_age    <= ({lcd_rs, lcd_rw} != ctl_q) ? 32'd1 :
                          ((ctl_age == '1) ? ctl_age : ctl_age + 32'd1);
            hi_len     <= lcd_e ? hi_len + 32'd1 : 32'd0;
            since_rise <= (lcd_e && !e_q) ? 32'd1 :
                          ((since_rise == '1) ? since_rise : since_rise + 32'd1);
        end
    end

    a_r5_oe_only_writing: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_db_oe |-> !lcd_rw);

    a_r5_oe_released_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_rw) |-> !$past(lcd_db_oe));

    a_r3_setup_met: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_e) |-> (ctl_age >= 32'(NS)) && $stable({lcd_rs, lcd_rw}));

    a_r4_high_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_e) |-> hi_len >= 32'(NH));

    a_r4_period: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_e) |-> since_rise >= 32'(NCY));

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_e) |=> $stable({lcd_rs, lcd_rw}));

    a_r10_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    a_r10_ack_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> !lcd_e && !lcd_rw && !lcd_db_oe);

endmodule

bind lcd_bus_engine lcd_bus_engine_chk #(.NS(NS), .NH(NH), .NCY(NCY)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .lcd_e     (lcd_e),
    .lcd_rs    (lcd_rs),
    .lcd_rw    (lcd_rw),
    .lcd_db_oe (lcd_db_oe),
    .ack       (ack)
);

// File: tb/lcd_bus_engine_tb_top.sv
`timescale 1ns/1ps
module lcd_bus_engine_tb_top;

    // Cycle counts at 200 MHz, taken from the requirements.
    localparam int NS   = 28;
    localparam int NH   = 90;
    localparam int NL   = 82;
    localparam int SAMP = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0, req_rs = 1'b0, req_rw = 1'b0, req_poll = 1'b0, req_nib = 1'b0;
    logic [7:0] req_byte = 8'h00;
    logic       ack, lcd_rs, lcd_rw, lcd_e, lcd_db_oe;
    logic [7:0] ack_data, lcd_db_out;
    logic [7:0] lcd_db_in = 8'hEE;

    always #2.5 clk = ~clk;

    lcd_bus_engine dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .req_rs(req_rs), .req_rw(req_rw),
        .req_poll(req_poll), .req_nib(req_nib), .req_byte(req_byte),
        .ack(ack), .ack_data(ack_data), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw),
        .lcd_e(lcd_e), .lcd_db_out(lcd_db_out), .lcd_db_oe(lcd_db_oe),
        .lcd_db_in(lcd_db_in)
    );

    typedef struct {
        bit       e, rs, rw, oe, ack, nib, poll;
        bit [7:0] dout, adata;
        int       ph;   // 0 setup, 1 high, 2 low, 3 ack, 4 idle
    } exp_t;

    exp_t       exp_q[$];
    logic [7:0] resp_q[$];
    int         vectors = 0, errors = 0;
    bit         running = 1'b0;
    int         e_cnt = 0;
    bit         e_prev = 1'b0;

    task automatic chk(input string tag, input string what, input int act, input int expv);
        vectors++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, expv, $time);
        end
    endtask

    // Append one strobe (setup, high, low) of expected cycles.
    task automatic push_pulse(input bit rs, input bit rw, input bit oe, input bit [7:0] d,
                              input bit nib, input bit poll);
        exp_t x;
        x.rs = rs; x.rw = rw; x.oe = oe; x.dout = d; x.ack = 0; x.adata = 0;
        x.nib = nib; x.poll = poll;
        for (int i = 0; i < NS; i++) begin x.e = 0; x.ph = 0; exp_q.push_back(x); end
        for (int i = 0; i < NH; i++) begin x.e = 1; x.ph = 1; exp_q.push_back(x); end
        for (int i = 0; i < NL; i++) begin x.e = 0; x.ph = 2; exp_q.push_back(x); end
    endtask

    // Reference model: expand an accepted request into its cycle list.
    task automatic build();
        bit       rs_e, rw_e, oe;
        bit [7:0] asm_b, d;
        int       idx, np;
        exp_t     a;
        rs_e = req_poll ? 1'b0 : req_rs;
        rw_e = req_poll | req_rw;
        oe   = !rw_e;
        np   = req_nib ? 2 : 1;
        idx  = 0;
        asm_b = 8'h00;
        do begin
            for (int p = 0; p < np; p++) begin
                if (!oe)          d = 8'h00;
                else if (!req_nib) d = req_byte;
                else if (p == 0)  d = {req_byte[7:4], 4'h0};
                else              d = {req_byte[3:0], 4'h0};
                if (rw_e) begin
                    if (!req_nib)    asm_b = resp_q[idx];
                    else if (p == 0) asm_b[7:4] = resp_q[idx][7:4];
                    else             asm_b[3:0] = resp_q[idx][7:4];
                    idx++;
                end
                push_pulse(rs_e, rw_e, oe, d, req_nib, req_poll);
            end
        end while (req_poll && asm_b[7]);
        a.e = 0; a.rs = 0; a.rw = 0; a.oe = 0; a.dout = 0; a.ack = 1;
        a.adata = rw_e ? asm_b : 8'h00; a.ph = 3; a.nib = req_nib; a.poll = req_poll;
        exp_q.push_back(a);
    endtask

    always @(posedge clk) begin
        if (running && rst_n && exp_q.size() == 0 && req) build();
    end

    // Display model: junk until the valid delay has passed, then planned data.
    always @(negedge clk) begin
        if (lcd_e) e_cnt++;
        else begin
            if (e_prev && lcd_rw && resp_q.size() > 0) void'(resp_q.pop_front());
            e_cnt = 0;
        end
        e_prev = lcd_e;
        lcd_db_in = (lcd_e && e_cnt >= SAMP && resp_q.size() > 0) ? resp_q[0] : 8'hEE;
    end

    // Compare every cycle against the model.
    always @(negedge clk) begin
        exp_t  x;
        string tc, td, ta;
        if (running) begin
            if (exp_q.size() > 0) x = exp_q.pop_front();
            else begin
                x.e = 0; x.rs = 0; x.rw = 0; x.oe = 0; x.dout = 0; x.ack = 0;
                x.adata = 0; x.ph = 4; x.nib = 0; x.poll = 0;
            end
            // Control tags: R3 setup, R2 strobe, R11 hold, R10 ack, R1 idle
            case (x.ph)
                0: tc = "R3";
                1: tc = "R2";
                2: tc = "R11";
                3: tc = "R10";
                default: tc = "R1";
            endcase
            td = x.nib ? "R6" : "R5";
            if (x.ph == 4) td = "R1";
            chk((x.ph == 4) ? "R1" : "R4", "strobe", lcd_e, x.e);
            chk(tc, "rs", lcd_rs, x.rs);
            chk(tc, "rw", lcd_rw, x.rw);
            chk((x.ph == 4) ? "R1" : "R5", "oe", lcd_db_oe, x.oe);
            chk(td, "db_out", lcd_db_out, x.dout);
            chk((x.ph == 4) ? "R1" : "R10", "ack", ack, x.ack);
            if (x.ack) begin
                ta = x.poll ? "R9" : (x.nib ? "R8" : "R7");
                chk(ta, "ack_data", ack_data, x.adata);
                req = 1'b0;
            end
        end
    end

    task automatic do_req(input bit rs, input bit rw, input bit poll, input bit nib,
                          input bit [7:0] b);
        @(negedge clk);
        req_rs = rs; req_rw = rw; req_poll = poll; req_nib = nib; req_byte = b;
        req = 1'b1;
        wait (req == 1'b0);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs quiet while in reset
        chk("R1", "strobe in reset", lcd_e, 0);
        chk("R1", "rw in reset", lcd_rw, 0);
        chk("R1", "oe in reset", lcd_db_oe, 0);
        chk("R1", "ack in reset", ack, 0);
        rst_n = 1'b1;
        running = 1'b1;
        repeat (4) @(negedge clk);
        do_req(0, 0, 0, 0, 8'h38);          // R5 wide instruction write
        do_req(1, 0, 0, 0, 8'h53);          // R2 wide data write
        do_req(0, 0, 0, 1, 8'h28);          // R6 narrow instruction write
        do_req(1, 0, 0, 1, 8'hC3);          // R6 narrow data write
        resp_q.push_back(8'h4D);
        do_req(1, 1, 0, 0, 8'hFF);          // R7 wide data read
        resp_q.push_back(8'h9A); resp_q.push_back(8'h5A);
        do_req(0, 1, 0, 1, 8'h00);          // R8 narrow status read -> 95
        resp_q.push_back(8'h85); resp_q.push_back(8'hFF); resp_q.push_back(8'h23);
        do_req(1, 0, 1, 0, 8'h77);          // R9 wide poll, three reads -> 23
        resp_q.push_back(8'h8A); resp_q.push_back(8'h1A);
        resp_q.push_back(8'h05); resp_q.push_back(8'h75);
        do_req(0, 0, 1, 1, 8'h00);          // R9 narrow poll, two bytes -> 07
        resp_q.push_back(8'h00);
        do_req(0, 1, 0, 0, 8'h00);          // R7 status read, not busy
        do_req(0, 0, 0, 0, 8'h01);          // R10 write right after a read
        repeat (10) @(negedge clk);
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog: actual no completion, expected completion");
        summary();
        $finish;
    end

endmodule